// File: doc/BRIEF.md
# Synchronous Card Answer-to-Reset Reader

This block sits on the reader side of a synchronous memory card link. When `start_i` arrives, it drives a reset pulse on the card reset line. After a timed pause it clocks out the card's fixed 32-bit answer-to-reset header. There is no start bit: one bit is captured on every rising edge of the card clock, least significant bit first.

All line timing comes from the system clock through tick-count parameters:
- the reset pulse width;
- the pause from the reset fall to the first clock rise;
- the clock high time, which is clamped to a maximum;
- the clock low time.

When all 32 bits are in, the block raises a one-cycle `done_o`. It also decides whether the card is compatible by comparing the first header byte (the protocol code) with a configured value. A mismatch raises a one-cycle `deact_o`, which the surrounding logic uses to deactivate the contacts.

Top module: `sync_atr_reader`

## Requirements
- R1: Each run captures exactly 32 bits, one per card clock rising edge. The first bit received lands in `header_o[0]` and the last in `header_o[31]`.
- R2: `h1_o` equals `header_o[7:0]` and `h2_o` equals `header_o[15:8]`.
- R3: An accepted start holds `card_rst_o` high for RST_TICKS cycles, then low. The card clock stays low during the reset pulse. It stays low for exactly SETUP_TICKS cycles after the reset fall before its first rise.
- R4: Every card clock high phase lasts min(HIGH_TICKS, HIGH_MAX_TICKS) cycles.
- R5: Between consecutive pulses the card clock stays low for LOW_TICKS cycles. Each run has exactly 32 rising edges.
- R6: `done_o` is a single-cycle pulse after the 32nd high phase ends.
  - `compat_o` is 1 from that cycle when `h1_o` equals SUPPORTED_H1, and otherwise 0. It holds that value until the next accepted start.
  - `deact_o` pulses together with `done_o` only when the card is not compatible.
- R7: `busy_o` is high from the cycle after an accepted start until the run ends, and low in the `done_o` cycle. A start request while busy is ignored and produces no second reset pulse.
- R8: After reset, `card_rst_o`, `card_clk_o`, `busy_o`, `done_o`, `deact_o` and `compat_o` are 0, and `header_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to read a header |
| card_io_i | input | 1 | Card data line |
| card_rst_o | output | 1 | Card reset line |
| card_clk_o | output | 1 | Card clock line |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-header strobe |
| compat_o | output | 1 | H1 matches the supported protocol code |
| deact_o | output | 1 | One-cycle request to deactivate contacts |
| header_o | output | 32 | Captured header, first bit at bit 0 |
| h1_o | output | 8 | Protocol field |
| h2_o | output | 8 | Second header field |

## Verification
The bench models a card that presents a new bit after each clock fall. It measures every reset, setup, high and low run length at the pins.

A configured high time above the limit exercises the clamp. A design that ignored the clamp would show over-long pulses.

All-zero and all-one headers catch a reversed bit order or an off-by-one shift. An off-by-one count would show 31 or 33 rising edges.

An H1 equal to the supported code, and one differing by a single bit, check that `compat_o` and `deact_o` are exclusive. A start issued mid-run checks that a design which restarted on it would emit a second reset pulse.

// File: rtl/atr_pkg.sv
package atr_pkg;
  localparam int unsigned HDR_BITS = 32;
  localparam int unsigned CNT_W    = $clog2(HDR_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RST, ST_SETUP, ST_HI, ST_LO, ST_FIN
  } atr_state_e;
endpackage

// File: rtl/atr_tick_timer.sv
module atr_tick_timer #(
  parameter int unsigned TICK_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [TICK_W-1:0] len_i,
  output logic              expired_o
);
  logic [TICK_W-1:0] cnt_q;

  // load N: expires after N cycles in the new state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= len_i - 1'b1;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  p_load_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (len_i != '0));
endmodule

// File: rtl/atr_shift_capture.sv
module atr_shift_capture
  import atr_pkg::*;
#(
  parameter int unsigned NBITS = HDR_BITS,
  localparam int unsigned CW   = $clog2(NBITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             bit_i,
  output logic [NBITS-1:0] word_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o
);
  logic [NBITS-1:0] word_q;
  logic [CW-1:0]    cnt_q;

  assign full_o = (cnt_q == CW'(NBITS));

  // LSB-first: newest bit enters at the top, first bit ends at bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
    end else if (shift_i && !full_o) begin
      word_q <= {bit_i, word_q[NBITS-1:1]};
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign word_o  = word_q;
  assign count_o = cnt_q;

  p_no_overshift_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |-> !full_o);
endmodule

// File: rtl/sync_atr_reader.sv
module sync_atr_reader
  import atr_pkg::*;
#(
  parameter int unsigned TICK_W         = 16,
  parameter int unsigned RST_TICKS      = 200,
  parameter int unsigned SETUP_TICKS    = 100,
  parameter int unsigned HIGH_TICKS     = 200,
  parameter int unsigned HIGH_MAX_TICKS = 500,
  parameter int unsigned LOW_TICKS      = 200,
  parameter logic [7:0]  SUPPORTED_H1   = 8'hA2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                card_io_i,
  output logic                card_rst_o,
  output logic                card_clk_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                compat_o,
  output logic                deact_o,
  output logic [HDR_BITS-1:0] header_o,
  output logic [7:0]          h1_o,
  output logic [7:0]          h2_o
);
  localparam int unsigned HIGH_EFF =
    (HIGH_TICKS > HIGH_MAX_TICKS) ? HIGH_MAX_TICKS : HIGH_TICKS;

  atr_state_e        state_q, state_d;
  logic              t_load, t_exp;
  logic [TICK_W-1:0] t_len;
  logic              cap_clr, cap_shift, cap_full;
  logic [CNT_W-1:0]  cap_cnt;
  logic              compat_q, h1_hit, fin;

  atr_tick_timer #(.TICK_W(TICK_W)) u_timer (
    .clk_i, .rst_ni, .load_i(t_load), .len_i(t_len), .expired_o(t_exp));

  atr_shift_capture #(.NBITS(HDR_BITS)) u_cap (
    .clk_i, .rst_ni, .clr_i(cap_clr), .shift_i(cap_shift), .bit_i(card_io_i),
    .word_o(header_o), .count_o(cap_cnt), .full_o(cap_full));

  always_comb begin
    state_d   = state_q;
    t_load    = 1'b0;
    t_len     = '0;
    cap_clr   = 1'b0;
    cap_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        state_d = ST_RST; t_load = 1'b1; t_len = TICK_W'(RST_TICKS); cap_clr = 1'b1;
      end
      ST_RST: if (t_exp) begin
        state_d = ST_SETUP; t_load = 1'b1; t_len = TICK_W'(SETUP_TICKS);
      end
      ST_SETUP, ST_LO: if (t_exp) begin
        // sample the data line on the edge that raises the card clock
        state_d = ST_HI; t_load = 1'b1; t_len = TICK_W'(HIGH_EFF); cap_shift = 1'b1;
      end
      ST_HI: if (t_exp) begin
        if (cap_full) state_d = ST_FIN;
        else begin
          state_d = ST_LO; t_load = 1'b1; t_len = TICK_W'(LOW_TICKS);
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign fin    = (state_q == ST_FIN);
  assign h1_hit = (header_o[7:0] == SUPPORTED_H1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          compat_q <= 1'b0;
    else if (state_q == ST_IDLE && start_i) compat_q <= 1'b0;
    else if (fin)                         compat_q <= h1_hit;
  end

  assign card_rst_o = (state_q == ST_RST);
  assign card_clk_o = (state_q == ST_HI);
  assign busy_o     = (state_q != ST_IDLE) && !fin;
  assign done_o     = fin;
  assign compat_o   = fin ? h1_hit : compat_q;
  assign deact_o    = fin && !h1_hit;
  assign h1_o       = header_o[7:0];
  assign h2_o       = header_o[15:8];

  // high-phase length monitor
  logic [TICK_W:0] hi_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         hi_run_q <= '0;
    else if (card_clk_o) hi_run_q <= hi_run_q + 1'b1;
    else                 hi_run_q <= '0;
  end

  p_high_bound_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_clk_o |-> (hi_run_q < (TICK_W+1)'(HIGH_MAX_TICKS)));
  p_clk_quiet_in_reset_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    card_rst_o |-> !card_clk_o);
  p_full_at_done_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cap_cnt == CNT_W'(HDR_BITS)));
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_deact_only_at_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deact_o |-> (done_o && !compat_o));
  p_no_restart_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(card_rst_o) |-> $past(!busy_o));
endmodule

// File: tb/sim_sync_atr_reader.sv
module sim_sync_atr_reader;
  localparam int CLK_PERIOD = 10;
  localparam int RST_T = 4, SETUP_T = 5, HIGH_T = 9, HIGH_MAX = 6, LOW_T = 3;
  localparam int HIGH_EXP = (HIGH_T > HIGH_MAX) ? HIGH_MAX : HIGH_T;
  localparam logic [7:0] SUP = 8'hA2;

  logic clk = 0, rst_n = 0, start = 0, io = 0;
  logic card_rst, card_clk, busy, done, compat, deact;
  logic [31:0] header;
  logic [7:0] h1, h2;

  int checks = 0, failures = 0;
  logic [31:0] card_word = '0;
  int idx, rst_run, setup_cnt, hi_run, lo_run, rises, rst_rises;
  int rst_w, setup_w, bad_hi, bad_lo, done_seen, deact_stray;
  bit in_setup, prev_rst, prev_clk;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_atr_reader #(.RST_TICKS(RST_T), .SETUP_TICKS(SETUP_T), .HIGH_TICKS(HIGH_T),
    .HIGH_MAX_TICKS(HIGH_MAX), .LOW_TICKS(LOW_T), .SUPPORTED_H1(SUP)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .card_io_i(io),
    .card_rst_o(card_rst), .card_clk_o(card_clk), .busy_o(busy), .done_o(done),
    .compat_o(compat), .deact_o(deact), .header_o(header), .h1_o(h1), .h2_o(h2));

  function automatic bit exp_compat(logic [31:0] w);
    return w[7:0] == SUP;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // card model and line timing monitor
  always @(negedge clk) begin
    if (card_rst && !prev_rst) rst_rises++;
    if (card_rst) rst_run++;
    if (prev_rst && !card_rst) begin
      rst_w = rst_run; rst_run = 0; setup_cnt = 0; in_setup = 1;
      idx = 0; io = card_word[0];
    end
    if (!card_rst && in_setup && !card_clk) setup_cnt++;
    if (card_clk && !prev_clk) begin
      if (in_setup) begin setup_w = setup_cnt; in_setup = 0; end
      if (rises > 0 && lo_run != LOW_T) bad_lo++;
      rises++; lo_run = 0;
    end
    if (card_clk) hi_run++;
    if (!card_clk && prev_clk) begin
      if (hi_run != HIGH_EXP) bad_hi++;
      hi_run = 0; lo_run = 0; idx++;
      if (idx < 32) io = card_word[idx];
    end
    if (!card_clk && rises > 0) lo_run++;
    if (done) done_seen++;
    if (deact && !done) deact_stray++;
    prev_rst = card_rst; prev_clk = card_clk;
  end

  task automatic run(logic [31:0] w, bit poke_busy);
    bit got = 0;
    bit ec = exp_compat(w);
    card_word = w;
    rst_run = 0; rises = 0; rst_rises = 0; bad_hi = 0; bad_lo = 0;
    done_seen = 0; deact_stray = 0; rst_w = -1; setup_w = -1;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    for (int i = 0; i < 5000 && !got; i++) begin
      @(negedge clk);
      if (poke_busy && i == 40) begin
        chk(busy == 1, "R7", "busy mid-run", busy, 1);
        start = 1;
      end
      if (poke_busy && i == 41) start = 0;
      if (done) begin
        got = 1;
        chk(header == w, "R1", "header", header, w);
        chk(h1 == w[7:0] && h2 == w[15:8], "R2", "h1/h2", {h2, h1}, w[15:0]);
        chk(compat == ec, "R6", "compat at done", compat, ec);
        chk(deact == !ec, "R6", "deact at done", deact, !ec);
        chk(busy == 0, "R7", "busy at done", busy, 0);
      end
    end
    chk(got, "R6", "done seen", got, 1);
    @(negedge clk);
    chk(done == 0 && deact == 0, "R6", "done/deact width", {done, deact}, 0);
    repeat (4) @(negedge clk);
    chk(compat == ec, "R6", "compat held", compat, ec);
    chk(done_seen == 1 && deact_stray == 0, "R6", "strobe count", done_seen, 1);
    chk(rst_w == RST_T, "R3", "rst width", rst_w, RST_T);
    chk(setup_w == SETUP_T, "R3", "setup gap", setup_w, SETUP_T);
    chk(bad_hi == 0, "R4", "bad high phases", bad_hi, 0);
    chk(bad_lo == 0, "R5", "bad low phases", bad_lo, 0);
    chk(rises == 32, "R5", "rising edges", rises, 32);
    chk(rst_rises == 1, "R7", "reset pulses", rst_rises, 1);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk({card_rst, card_clk, busy, done, deact, compat} == 0, "R8", "reset outputs",
        {card_rst, card_clk, busy, done, deact, compat}, 0);
    chk(header == 0, "R8", "reset header", header, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    run(32'h0000_0000, 0);
    run(32'hFFFF_FFFF, 0);
    run({24'h5C3E91, SUP}, 0);
    run({24'h13579B, SUP ^ 8'h01}, 1);
    run(32'h8000_00A2, 0);
    for (int k = 0; k < 6; k++) begin
      logic [31:0] w = $urandom;
      if (k[0]) w[7:0] = SUP;
      run(w, k == 2);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule